// File: doc/BRIEF.md
# Receive Packet Store Controller

This block takes in a frame that address filtering has already accepted, one data word per cycle, and stores it in a paged packet memory. When the first word arrives, the block claims the lowest-numbered free page. That page index becomes the packet's handle. Payload words go to consecutive logical word addresses starting at word 2. Each logical address is mapped to a physical memory address through the packet's own list of pages. When the logical address crosses into a new page, another page is claimed. All memory writes leave the block as a registered write strobe with an address and data.

At the end of the frame the block reads the CRC verdict and the odd-byte flag that arrive with the last word. If the CRC is good, it fills the two reserved header words with a status word and a byte count, then queues the packet handle in a receive queue. If the CRC is bad, or if memory ran out during the frame, every page of the packet goes back to the free pool and nothing is queued. The interrupt line is high whenever the queue holds a packet. Software reads the oldest handle and, once it is done with the packet, issues a release command that pops the queue and frees the packet's pages.

Top module: `rx_pkt_store`

## Requirements
- R1: A word with rx_sof, accepted while idle with at least one free page, claims the lowest-numbered free page. That page index is the packet number, and the word is written to offset 2 of that page.
- R2: Payload words take consecutive logical addresses from 2 upward. The physical address is page_list[L/128]*128 + L%128, on a 12-bit address. Each write appears on mem_we/mem_addr/mem_wdata one cycle after the word is accepted.
- R3: A further page, the lowest-numbered free one, is claimed only when a word's logical address is a nonzero multiple of 128. A frame of 126 payload words therefore uses one page, and 127 payload words use two.
- R4: Overrun occurs when no page is free for a word that needs one, or when a ninth page would be needed. On overrun, that word and every later word of the frame produce no write, all pages of the packet are freed, and nothing is queued.
- R5: With good CRC, after the last payload write the block writes the status word to offset 0 of the first page, then the byte count to offset 1. In the status word, bit 12 is the odd-final-byte flag and all other bits are 0. The byte count is 2*(payload words + 2), minus 1 when the odd flag is set. The packet number is then queued.
- R6: With bad CRC, no header word is written, all pages of the packet are freed, and the interrupt does not change.
- R7: rx_irq is high exactly when the receive queue holds at least one packet, and rx_top_pkt then shows the oldest queued packet number.
- R8: cmd_release removes the oldest queued packet and returns all of its pages to the free pool. When the queue is empty, cmd_release has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | A frame word is present |
| rx_sof | input | 1 | The word is the first of a frame |
| rx_eof | input | 1 | The word is the last of a frame |
| rx_crc_ok | input | 1 | CRC verdict, read with rx_eof |
| rx_odd | input | 1 | Last word carries one byte, read with rx_eof |
| rx_data | input | 16 | Frame word |
| cmd_release | input | 1 | Remove and free the oldest queued packet |
| rx_irq | output | 1 | Receive queue not empty |
| rx_top_pkt | output | 5 | Oldest queued packet number |
| mem_we | output | 1 | Packet memory write strobe |
| mem_addr | output | 12 | Physical word address |
| mem_wdata | output | 16 | Word to write |

## Verification
The assertions check four things on every cycle. Every write lands in a page that is currently owned. A page is never claimed while the pool is empty. The interrupt rises only right after a packet is queued. A release shrinks the queue by exactly one, and a release on an empty queue leaves it empty. Only the bench's scenarios can show the rest, because each depends on a whole frame's history: which page number gets chosen, where page boundaries fall at 126 and 127 words, whether the header values are right, and whether pages return to the pool after a bad CRC, an overrun or a release.

// File: rtl/rxps_pkg.sv
package rxps_pkg;

    typedef enum logic [2:0] {
        WR_IDLE,
        WR_RECV,
        WR_DROP,
        WR_HDR0,
        WR_HDR1
    } wr_state_e;

    // header layout: word 0 status, word 1 byte count, payload from word 2
    localparam int HDR_WORDS      = 2;
    localparam int STATUS_ODD_BIT = 12;

    // bytes held by a packet of 'words' words, last one possibly half used
    function automatic int unsigned pkt_bytes(input int unsigned words, input logic odd);
        return 2 * words - (odd ? 1 : 0);
    endfunction

endpackage

// File: rtl/rxps_page_alloc.sv
module rxps_page_alloc #(
    parameter int NUM_PAGES = 32,
    parameter int PG_W      = 5
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 alloc_req,
    input  logic [NUM_PAGES-1:0] drop_mask,
    input  logic                 store_en,
    input  logic [PG_W-1:0]      store_pkt,
    input  logic [NUM_PAGES-1:0] store_mask,
    input  logic                 free_en,
    input  logic [PG_W-1:0]      free_pkt,
    output logic                 alloc_ok,
    output logic [PG_W-1:0]      alloc_idx,
    output logic [NUM_PAGES-1:0] free_map
);

    logic [NUM_PAGES-1:0] owned [NUM_PAGES];
    logic [NUM_PAGES-1:0] take_mask;
    logic [NUM_PAGES-1:0] give_mask;

    // lowest-numbered free page wins
    always_comb begin
        alloc_idx = '0;
        for (int i = NUM_PAGES - 1; i >= 0; i--) begin
            if (free_map[i]) alloc_idx = PG_W'(i);
        end
    end

    assign alloc_ok = |free_map;

    always_comb begin
        take_mask = '0;
        if (alloc_req && alloc_ok) take_mask[alloc_idx] = 1'b1;
        give_mask = drop_mask | (free_en ? owned[free_pkt] : '0);
    end

    always_ff @(posedge clk) begin
        if (rst) free_map <= '1;
        else     free_map <= (free_map & ~take_mask) | give_mask;
    end

    // page set of each committed packet, indexed by packet number
    for (genvar g = 0; g < NUM_PAGES; g++) begin : g_owned
        always_ff @(posedge clk) begin
            if (rst)                                   owned[g] <= '0;
            else if (store_en && store_pkt == PG_W'(g)) owned[g] <= store_mask;
        end
    end

endmodule

// File: rtl/rxps_pkt_fifo.sv
module rxps_pkt_fifo #(
    parameter int DEPTH = 32,
    parameter int W     = 5,
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [W-1:0]     push_val,
    input  logic             pop,
    output logic [W-1:0]     head,
    output logic [CNT_W-1:0] cnt
);

    localparam int PTR_W = $clog2(DEPTH);

    logic [W-1:0]     slots [DEPTH];
    logic [PTR_W-1:0] rd_ptr;
    logic [PTR_W-1:0] wr_ptr;
    logic             do_pop;

    assign do_pop = pop && (cnt != '0);
    assign head   = slots[rd_ptr];

    always_ff @(posedge clk) begin
        if (push) slots[wr_ptr] <= push_val;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push)   wr_ptr <= wr_ptr + 1'b1;
            if (do_pop) rd_ptr <= rd_ptr + 1'b1;
            case ({push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

endmodule

// File: rtl/rxps_writer.sv
module rxps_writer
    import rxps_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int PAGE_AW   = 7,
    parameter int NUM_PAGES = 32,
    parameter int PG_W      = 5,
    parameter int MAX_PG    = 8,
    parameter int SEL_W     = 3,
    parameter int USED_W    = 4,
    parameter int LOG_W     = 10,
    parameter int ADDR_W    = 12
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rx_valid,
    input  logic                 rx_sof,
    input  logic                 rx_eof,
    input  logic                 rx_crc_ok,
    input  logic                 rx_odd,
    input  logic [DATA_W-1:0]    rx_data,
    input  logic                 alloc_ok,
    input  logic [PG_W-1:0]      alloc_idx,
    output logic                 alloc_req,
    output logic [NUM_PAGES-1:0] drop_mask,
    output logic                 store_en,
    output logic [PG_W-1:0]      store_pkt,
    output logic [NUM_PAGES-1:0] store_mask,
    output logic                 push,
    output logic [PG_W-1:0]      push_pkt,
    output logic                 mem_we,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [DATA_W-1:0]    mem_wdata
);

    wr_state_e            state;
    logic [LOG_W:0]       lcnt;
    logic [USED_W-1:0]    used;
    logic [PG_W-1:0]      plist [MAX_PG];
    logic [NUM_PAGES-1:0] pmask;
    logic                 crc_q;
    logic                 odd_q;

    logic                 is_idle;
    logic                 take;
    logic [LOG_W:0]       cur_l;
    logic [USED_W-1:0]    cur_used;
    logic                 need_pg;
    logic                 no_room;
    logic [PG_W-1:0]      wr_page;
    logic [NUM_PAGES-1:0] new_bit;
    logic [DATA_W-1:0]    status_word;
    logic [DATA_W-1:0]    count_word;

    assign is_idle  = (state == WR_IDLE);
    assign take     = rx_valid && ((is_idle && rx_sof) || state == WR_RECV);
    assign cur_l    = is_idle ? (LOG_W + 1)'(HDR_WORDS) : lcnt;
    assign cur_used = is_idle ? '0 : used;
    assign need_pg  = is_idle || (cur_l[PAGE_AW-1:0] == '0);
    assign no_room  = need_pg && ((cur_used == USED_W'(MAX_PG)) || !alloc_ok);
    assign alloc_req = take && need_pg && !no_room;
    assign wr_page  = need_pg ? alloc_idx : plist[cur_l[LOG_W-1:PAGE_AW]];

    always_comb begin
        new_bit = '0;
        new_bit[alloc_idx] = 1'b1;
    end

    always_comb begin
        drop_mask = '0;
        if (take && no_room && !is_idle)      drop_mask = pmask;
        else if (state == WR_HDR0 && !crc_q)  drop_mask = pmask;
    end

    assign store_en   = (state == WR_HDR1);
    assign store_pkt  = plist[0];
    assign store_mask = pmask;
    assign push       = store_en;
    assign push_pkt   = plist[0];

    assign status_word = DATA_W'(odd_q) << STATUS_ODD_BIT;
    assign count_word  = DATA_W'(pkt_bytes(32'(lcnt), odd_q));

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= WR_IDLE;
            lcnt      <= '0;
            used      <= '0;
            pmask     <= '0;
            crc_q     <= 1'b0;
            odd_q     <= 1'b0;
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
            for (int i = 0; i < MAX_PG; i++) plist[i] <= '0;
        end else begin
            mem_we <= 1'b0;
            case (state)
                WR_IDLE, WR_RECV: begin
                    if (take) begin
                        if (no_room) begin
                            state <= rx_eof ? WR_IDLE : WR_DROP;
                        end else begin
                            mem_we    <= 1'b1;
                            mem_addr  <= {wr_page, cur_l[PAGE_AW-1:0]};
                            mem_wdata <= rx_data;
                            lcnt      <= cur_l + 1'b1;
                            if (need_pg) begin
                                plist[cur_used[SEL_W-1:0]] <= alloc_idx;
                                used  <= cur_used + 1'b1;
                                pmask <= (is_idle ? '0 : pmask) | new_bit;
                            end
                            if (rx_eof) begin
                                state <= WR_HDR0;
                                crc_q <= rx_crc_ok;
                                odd_q <= rx_odd;
                            end else begin
                                state <= WR_RECV;
                            end
                        end
                    end
                end
                WR_HDR0: begin
                    if (crc_q) begin
                        mem_we    <= 1'b1;
                        mem_addr  <= {plist[0], PAGE_AW'(0)};
                        mem_wdata <= status_word;
                        state     <= WR_HDR1;
                    end else begin
                        state <= WR_IDLE;
                    end
                end
                WR_HDR1: begin
                    mem_we    <= 1'b1;
                    mem_addr  <= {plist[0], PAGE_AW'(1)};
                    mem_wdata <= count_word;
                    state     <= WR_IDLE;
                end
                WR_DROP: begin
                    if (rx_valid && rx_eof) state <= WR_IDLE;
                end
                default: state <= WR_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/rx_pkt_store.sv
module rx_pkt_store #(
    parameter int DATA_W        = 16,
    parameter int PAGE_WORDS    = 128,
    parameter int NUM_PAGES     = 32,
    parameter int MAX_PKT_PAGES = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          rx_valid,
    input  logic                          rx_sof,
    input  logic                          rx_eof,
    input  logic                          rx_crc_ok,
    input  logic                          rx_odd,
    input  logic [DATA_W-1:0]             rx_data,
    input  logic                          cmd_release,
    output logic                          rx_irq,
    output logic [$clog2(NUM_PAGES)-1:0]  rx_top_pkt,
    output logic                          mem_we,
    output logic [$clog2(NUM_PAGES)+$clog2(PAGE_WORDS)-1:0] mem_addr,
    output logic [DATA_W-1:0]             mem_wdata
);

    localparam int PG_W    = $clog2(NUM_PAGES);
    localparam int PAGE_AW = $clog2(PAGE_WORDS);
    localparam int SEL_W   = $clog2(MAX_PKT_PAGES);
    localparam int USED_W  = $clog2(MAX_PKT_PAGES + 1);
    localparam int LOG_W   = PAGE_AW + SEL_W;
    localparam int ADDR_W  = PG_W + PAGE_AW;
    localparam int CNT_W   = $clog2(NUM_PAGES + 1);

    logic                 alloc_req;
    logic                 alloc_ok;
    logic [PG_W-1:0]      alloc_idx;
    logic [NUM_PAGES-1:0] drop_mask;
    logic                 store_en;
    logic [PG_W-1:0]      store_pkt;
    logic [NUM_PAGES-1:0] store_mask;
    logic [NUM_PAGES-1:0] free_map;
    logic                 fifo_push;
    logic [PG_W-1:0]      push_pkt;
    logic [CNT_W-1:0]     fifo_cnt;
    logic                 rel_go;

    assign rx_irq = (fifo_cnt != '0);
    assign rel_go = cmd_release && rx_irq;

    rxps_writer #(
        .DATA_W(DATA_W), .PAGE_AW(PAGE_AW), .NUM_PAGES(NUM_PAGES), .PG_W(PG_W),
        .MAX_PG(MAX_PKT_PAGES), .SEL_W(SEL_W), .USED_W(USED_W), .LOG_W(LOG_W),
        .ADDR_W(ADDR_W)
    ) u_writer (
        .clk(clk), .rst(rst),
        .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof),
        .rx_crc_ok(rx_crc_ok), .rx_odd(rx_odd), .rx_data(rx_data),
        .alloc_ok(alloc_ok), .alloc_idx(alloc_idx), .alloc_req(alloc_req),
        .drop_mask(drop_mask), .store_en(store_en), .store_pkt(store_pkt),
        .store_mask(store_mask), .push(fifo_push), .push_pkt(push_pkt),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    rxps_page_alloc #(.NUM_PAGES(NUM_PAGES), .PG_W(PG_W)) u_alloc (
        .clk(clk), .rst(rst),
        .alloc_req(alloc_req), .drop_mask(drop_mask),
        .store_en(store_en), .store_pkt(store_pkt), .store_mask(store_mask),
        .free_en(rel_go), .free_pkt(rx_top_pkt),
        .alloc_ok(alloc_ok), .alloc_idx(alloc_idx), .free_map(free_map)
    );

    rxps_pkt_fifo #(.DEPTH(NUM_PAGES), .W(PG_W), .CNT_W(CNT_W)) u_fifo (
        .clk(clk), .rst(rst),
        .push(fifo_push), .push_val(push_pkt), .pop(cmd_release),
        .head(rx_top_pkt), .cnt(fifo_cnt)
    );

endmodule

// File: rtl/rx_pkt_store_chk.sv
module rx_pkt_store_chk #(
    parameter int NUM_PAGES = 32,
    parameter int PAGE_AW   = 7,
    parameter int ADDR_W    = 12,
    parameter int CNT_W     = 6
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 rx_irq,
    input logic                 cmd_release,
    input logic                 mem_we,
    input logic [ADDR_W-1:0]    mem_addr,
    input logic [NUM_PAGES-1:0] free_map,
    input logic                 fifo_push,
    input logic [CNT_W-1:0]     fifo_cnt,
    input logic                 alloc_req,
    input logic                 alloc_ok
);

    // writes target only pages that are currently owned
    assert_write_owned_R2: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> !free_map[mem_addr[ADDR_W-1:PAGE_AW]]);

    // a page is only claimed while the pool holds one
    assert_claim_avail_R4: assert property (@(posedge clk) disable iff (rst)
        alloc_req |-> alloc_ok);

    // interrupt rises only right after a commit
    assert_irq_rise_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_irq) |-> $past(fifo_push));

    // a release on a non-empty queue removes exactly one entry
    assert_pop_one_R8: assert property (@(posedge clk) disable iff (rst)
        (cmd_release && rx_irq && !fifo_push) |=> (fifo_cnt == $past(fifo_cnt) - 1'b1));

    // a release on an empty queue leaves it empty
    assert_pop_empty_R8: assert property (@(posedge clk) disable iff (rst)
        (cmd_release && !rx_irq && !fifo_push) |=> (fifo_cnt == '0));

endmodule

bind rx_pkt_store rx_pkt_store_chk #(
    .NUM_PAGES(NUM_PAGES), .PAGE_AW(PAGE_AW), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst(rst), .rx_irq(rx_irq), .cmd_release(cmd_release),
    .mem_we(mem_we), .mem_addr(mem_addr), .free_map(free_map),
    .fifo_push(fifo_push), .fifo_cnt(fifo_cnt),
    .alloc_req(alloc_req), .alloc_ok(alloc_ok)
);

// File: tb/rx_pkt_store_test.sv
`timescale 1ns/1ps
module rx_pkt_store_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
    logic        rx_crc_ok = 1'b0, rx_odd = 1'b0;
    logic [15:0] rx_data = '0;
    logic        cmd_release = 1'b0;
    logic        rx_irq;
    logic [4:0]  rx_top_pkt;
    logic        mem_we;
    logic [11:0] mem_addr;
    logic [15:0] mem_wdata;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    rx_pkt_store uut (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof),
        .rx_crc_ok(rx_crc_ok), .rx_odd(rx_odd), .rx_data(rx_data),
        .cmd_release(cmd_release), .rx_irq(rx_irq), .rx_top_pkt(rx_top_pkt),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    // reference model state
    typedef struct {int addr; int data; string req;} exp_wr_t;
    exp_wr_t exp_q[$];
    int      pkt_q[$];
    bit      mfree [32];
    int      ptab  [32][$];

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int lowest_free();
        for (int i = 0; i < 32; i++) if (mfree[i]) return i;
        return -1;
    endfunction

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            if (mem_we) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2", {mem_addr, mem_wdata}, 0);
                end else begin
                    exp_wr_t e;
                    e = exp_q.pop_front();
                    chk(mem_addr == e.addr[11:0] && mem_wdata == e.data[15:0], e.req,
                        {mem_addr, mem_wdata}, {e.addr[11:0], e.data[15:0]});
                end
            end
            chk(rx_irq == (pkt_q.size() != 0), "R7", rx_irq, pkt_q.size() != 0);
            if (pkt_q.size() != 0) chk(rx_top_pkt == pkt_q[0], "R7", rx_top_pkt, pkt_q[0]);
        end
    end

    task automatic send_frame(input int n, input bit crc, input bit odd, input int base,
                              output int pkt);
        int  pages[$];
        bit  dropped = 0;
        int  l = 2;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_valid  = 1'b1;
            rx_sof    = (i == 0);
            rx_eof    = (i == n - 1);
            rx_crc_ok = crc;
            rx_odd    = odd;
            rx_data   = 16'((base + i) & 16'hFFFF);
            if (!dropped) begin
                if (i == 0 || (l % 128) == 0) begin
                    int p;
                    p = lowest_free();
                    if (pages.size() == 8 || p < 0) begin
                        dropped = 1;
                        foreach (pages[k]) mfree[pages[k]] = 1'b1;
                        pages.delete();
                    end else begin
                        mfree[p] = 1'b0;
                        pages.push_back(p);
                    end
                end
                if (!dropped) begin
                    exp_q.push_back('{pages[l / 128] * 128 + (l % 128), int'(rx_data), "R2"});
                    l++;
                end
            end
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
        if (!dropped && crc) begin
            exp_q.push_back('{pages[0] * 128, odd ? (1 << 12) : 0, "R5"});
            exp_q.push_back('{pages[0] * 128 + 1, 2 * l - (odd ? 1 : 0), "R5"});
        end
        @(posedge clk);
        @(posedge clk);
        if (dropped) begin
            pkt = -1;
        end else if (crc) begin
            pkt = pages[0];
            ptab[pages[0]] = pages;
            pkt_q.push_back(pages[0]);
        end else begin
            pkt = -1;
            foreach (pages[k]) mfree[pages[k]] = 1'b1;
        end
    endtask

    task automatic release_top();
        @(negedge clk);
        cmd_release = 1'b1;
        @(posedge clk);
        if (pkt_q.size() != 0) begin
            int p;
            p = pkt_q.pop_front();
            foreach (ptab[p][k]) mfree[ptab[p][k]] = 1'b1;
        end
        @(negedge clk);
        cmd_release = 1'b0;
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL R7: watchdog expired, actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int p;
        foreach (mfree[i]) mfree[i] = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk(rx_irq == 1'b0, "R7", rx_irq, 0);
        chk(mem_we == 1'b0, "R2", mem_we, 0);

        send_frame(10, 1, 0, 16'h1000, p);  chk(p == 0, "R1", p, 0);
        send_frame(126, 1, 1, 16'h2000, p); chk(p == 1, "R3", p, 1);
        send_frame(127, 1, 0, 16'h3000, p); chk(p == 2, "R3", p, 2);
        send_frame(3, 1, 1, 16'h4000, p);   chk(p == 4, "R3", p, 4);

        // bad CRC: pages 5 and 6 are claimed then returned
        send_frame(200, 0, 1, 16'h5000, p); chk(p == -1, "R6", p, -1);
        chk(pkt_q.size() == 4 && rx_irq, "R6", rx_irq, 1);
        send_frame(4, 1, 0, 16'h6000, p);   chk(p == 5, "R6", p, 5);

        repeat (5) release_top();
        chk(rx_irq == 1'b0, "R8", rx_irq, 0);
        release_top();                       // empty queue
        chk(rx_irq == 1'b0, "R8", rx_irq, 0);
        send_frame(2, 1, 1, 16'h7000, p);   chk(p == 0, "R8", p, 0);
        release_top();

        // ninth page needed: overrun
        send_frame(1023, 1, 0, 16'h8000, p); chk(p == -1, "R4", p, -1);
        chk(rx_irq == 1'b0, "R4", rx_irq, 0);
        send_frame(1, 1, 1, 16'h9000, p);    chk(p == 0, "R4", p, 0);
        release_top();

        // fill the whole pool with maximum-size packets
        for (int k = 0; k < 4; k++) begin
            send_frame(1022, 1, 0, 16'hA000 + k * 16'h0400, p);
            chk(p == 8 * k, "R3", p, 8 * k);
        end
        send_frame(5, 1, 0, 16'hB000, p);    chk(p == -1, "R4", p, -1);
        chk(pkt_q.size() == 4, "R4", pkt_q.size(), 4);
        release_top();
        send_frame(6, 1, 0, 16'hC000, p);    chk(p == 0, "R8", p, 0);
        repeat (4) release_top();
        chk(rx_irq == 1'b0, "R8", rx_irq, 0);
        chk(exp_q.size() == 0, "R2", exp_q.size(), 0);

        repeat (3) @(posedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule